// File: doc/BRIEF.md
# Shared Cartridge ROM Arbiter

This block shares one cartridge ROM port between a host processor and a graphics coprocessor. Two control inputs decide who owns the ROM: a flag that says the coprocessor is running and a bit that hands the ROM to it. The coprocessor owns the ROM only when both are set.

While the coprocessor owns the ROM, a host read never reaches the device. The host instead gets, in the same cycle, a fixed byte chosen by the low four address bits. This pattern steers the host's interrupt vector fetches into work RAM. While the host owns the ROM, a coprocessor request is left ungranted, and the coprocessor waits until ownership is handed back.

Every ROM access takes a fixed number of master clocks: 6 in fast mode or 8 in slow mode, chosen per access. The requester is told the data is valid on the last clock of the access.

Top module: `rom_share_arb`

## Requirements
- R1: When `cpRunning` and `cpOwnsRom` are both 1, a host read returns a fixed byte in the same cycle, with `hostValid` high. The byte is indexed by `hostAddr[3:0]` and the table is 00,01,00,01,04,01,00,01,00,01,08,01,00,01,0C,01 (hex), for index 0 upward.
- R2: A host read served from that fixed table never asserts `romCs`.
- R3: When either control bit is 0, a host read runs a real ROM access at `hostAddr` and returns the ROM byte.
- R4: While the host owns the ROM, a held coprocessor request gets no grant, no ROM access and no `cpValid`. Once ownership is handed over, the coprocessor is served.
- R5: An access with its speed select at 1 keeps `romCs` high for exactly 6 clocks. With the speed select at 0, `romCs` stays high for exactly 8 clocks.
- R6: `hostValid` or `cpValid` for a ROM access is high for exactly one clock: the last clock in which `romCs` is high.
- R7: `cpGrant` is a register that changes only while no access is in flight, or on the last clock of an access.
- R8: After reset, `cpGrant`, `romCs`, `hostValid` and `cpValid` are all 0.
- R9: An access that has started completes for the owner that started it, even if ownership changes during the access. `romAddr` holds its value for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rstN | input | 1 | active-low synchronous reset |
| cpRunning | input | 1 | coprocessor-running flag |
| cpOwnsRom | input | 1 | ROM handed to the coprocessor |
| hostReq | input | 1 | host read request, held until `hostValid` |
| hostAddr | input | ADDR_W | host read address |
| hostFast | input | 1 | host access speed: 1 = 6 clocks, 0 = 8 clocks |
| hostData | output | 8 | host read data |
| hostValid | output | 1 | host data valid |
| cpReq | input | 1 | coprocessor read request, held until `cpValid` |
| cpAddr | input | ADDR_W | coprocessor read address |
| cpFast | input | 1 | coprocessor access speed |
| cpGrant | output | 1 | registered coprocessor ownership grant |
| cpData | output | 8 | coprocessor read data |
| cpValid | output | 1 | coprocessor data valid |
| romCs | output | 1 | ROM chip select |
| romAddr | output | ADDR_W | ROM address |
| romData | input | 8 | ROM read data |

## Verification
A fixed-table read is combinational, so its checks sample one time unit after the inputs are driven, in the same cycle. A ROM read that starts from idle raises its valid N falling edges after the request, where N is 6 or 8. The bench counts falling edges from the request and compares the count with N, and it checks `romCs` on every edge before the valid. A coprocessor waiting on a handover sees its grant one edge after the control bits are set and its valid N+1 edges after them, and the bench samples at exactly those edges.

// File: rtl/rom_arb_pkg.sv
package rom_arb_pkg;
  typedef struct packed {
    logic capHost;   // latch host address into ROM address register
    logic capCp;     // latch coprocessor address into ROM address register
    logic dummyOn;   // host read served from the fixed table
  } arbStrobe_t;
endpackage

// File: rtl/rom_arb_ctrl.sv
module rom_arb_ctrl
  import rom_arb_pkg::*;
#(
  parameter int FAST_CYC = 6,
  parameter int SLOW_CYC = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpRunning,
  input  logic       cpOwnsRom,
  input  logic       hostReq,
  input  logic       hostFast,
  input  logic       cpReq,
  input  logic       cpFast,
  output arbStrobe_t strobe,
  output logic       romCs,
  output logic       hostValid,
  output logic       cpValid,
  output logic       cpGrant
);
  localparam int CntW = $clog2(SLOW_CYC + 1);
  localparam logic [CntW-1:0] FastLast = CntW'(FAST_CYC - 1);
  localparam logic [CntW-1:0] SlowLast = CntW'(SLOW_CYC - 1);

  logic busyQ, ownerCpQ, grantQ;
  logic [CntW-1:0] cntQ, lastQ;
  logic coOwns, endCycle, startCp, startHost, dummyOn;

  assign coOwns    = cpRunning & cpOwnsRom;
  assign endCycle  = busyQ && (cntQ == lastQ);
  assign startCp   = !busyQ && grantQ && coOwns && cpReq;
  assign startHost = !busyQ && !grantQ && !coOwns && hostReq;
  assign dummyOn   = hostReq && coOwns;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      ownerCpQ <= 1'b0;
      grantQ   <= 1'b0;
      cntQ     <= '0;
      lastQ    <= SlowLast;
    end else begin
      if (!busyQ || endCycle) grantQ <= coOwns;
      if (startCp || startHost) begin
        busyQ    <= 1'b1;
        cntQ     <= '0;
        ownerCpQ <= startCp;
        lastQ    <= (startCp ? cpFast : hostFast) ? FastLast : SlowLast;
      end else if (endCycle) begin
        busyQ <= 1'b0;
      end else if (busyQ) begin
        cntQ <= cntQ + 1'b1;
      end
    end
  end

  assign strobe.capHost = startHost;
  assign strobe.capCp   = startCp;
  assign strobe.dummyOn = dummyOn;
  assign romCs     = busyQ;
  assign cpGrant   = grantQ;
  assign cpValid   = endCycle && ownerCpQ;
  assign hostValid = dummyOn || (endCycle && !ownerCpQ);

  // R2: a lone host read under coprocessor ownership starts no ROM cycle
  a_r2_dummy_no_rom: assert property (@(posedge clk) disable iff (!rstN)
    (hostReq && coOwns && !busyQ && !cpReq) |=> !romCs);
  // R4: a coprocessor access only begins while it holds the grant
  a_r4_cp_needs_grant: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(romCs) && ownerCpQ) |-> $past(grantQ));
  // R6: valid strobe lasts one clock and ends the access
  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    (cpValid || (endCycle && !ownerCpQ)) |=> !romCs);
  // R7: grant moves only on an access boundary
  a_r7_grant_boundary: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(grantQ) |-> $past(!busyQ || endCycle));
  // R9: owner of an access is fixed while it runs
  a_r9_owner_fixed: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && $past(busyQ) && !$past(endCycle)) |-> $stable(ownerCpQ));
endmodule

// File: rtl/rom_arb_dp.sv
module rom_arb_dp
  import rom_arb_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  arbStrobe_t        strobe,
  input  logic              romCs,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [ADDR_W-1:0] cpAddr,
  input  logic [7:0]        romData,
  output logic [ADDR_W-1:0] romAddr,
  output logic [7:0]        hostData,
  output logic [7:0]        cpData
);
  logic [ADDR_W-1:0] addrQ;

  function automatic logic [7:0] vecByte(input logic [3:0] idx);
    if (idx[0]) return 8'h01;
    case (idx[3:1])
      3'd2:    return 8'h04;
      3'd5:    return 8'h08;
      3'd7:    return 8'h0C;
      default: return 8'h00;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) addrQ <= '0;
    else if (strobe.capCp) addrQ <= cpAddr;
    else if (strobe.capHost) addrQ <= hostAddr;
  end

  assign romAddr  = addrQ;
  assign hostData = strobe.dummyOn ? vecByte(hostAddr[3:0]) : romData;
  assign cpData   = romData;

  // R9: ROM address is steady for the whole access
  a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (romCs && $past(romCs) && !$past(strobe.capHost || strobe.capCp)) |-> $stable(romAddr));
endmodule

// File: rtl/rom_share_arb.sv
module rom_share_arb
  import rom_arb_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int FAST_CYC = 6,
  parameter int SLOW_CYC = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpRunning,
  input  logic              cpOwnsRom,
  input  logic              hostReq,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostFast,
  output logic [7:0]        hostData,
  output logic              hostValid,
  input  logic              cpReq,
  input  logic [ADDR_W-1:0] cpAddr,
  input  logic              cpFast,
  output logic              cpGrant,
  output logic [7:0]        cpData,
  output logic              cpValid,
  output logic              romCs,
  output logic [ADDR_W-1:0] romAddr,
  input  logic [7:0]        romData
);
  arbStrobe_t strobe;

  rom_arb_ctrl #(.FAST_CYC(FAST_CYC), .SLOW_CYC(SLOW_CYC)) i_ctrl (
    .clk(clk), .rstN(rstN), .cpRunning(cpRunning), .cpOwnsRom(cpOwnsRom),
    .hostReq(hostReq), .hostFast(hostFast), .cpReq(cpReq), .cpFast(cpFast),
    .strobe(strobe), .romCs(romCs), .hostValid(hostValid), .cpValid(cpValid),
    .cpGrant(cpGrant)
  );

  rom_arb_dp #(.ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .romCs(romCs),
    .hostAddr(hostAddr), .cpAddr(cpAddr), .romData(romData),
    .romAddr(romAddr), .hostData(hostData), .cpData(cpData)
  );
endmodule

// File: tb/test_rom_share_arb.sv
module test_rom_share_arb;
  logic clk = 0, rstN = 0;
  logic cpRunning = 0, cpOwnsRom = 0, hostReq = 0, hostFast = 0, cpReq = 0, cpFast = 0;
  logic [15:0] hostAddr = 0, cpAddr = 0, romAddr;
  logic [7:0] hostData, cpData, romData;
  logic hostValid, cpValid, cpGrant, romCs;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign romData = romAddr[7:0] ^ romAddr[15:8] ^ 8'h5A;

  rom_share_arb i_rom_share_arb (
    .clk(clk), .rstN(rstN), .cpRunning(cpRunning), .cpOwnsRom(cpOwnsRom),
    .hostReq(hostReq), .hostAddr(hostAddr), .hostFast(hostFast),
    .hostData(hostData), .hostValid(hostValid), .cpReq(cpReq), .cpAddr(cpAddr),
    .cpFast(cpFast), .cpGrant(cpGrant), .cpData(cpData), .cpValid(cpValid),
    .romCs(romCs), .romAddr(romAddr), .romData(romData)
  );

  function automatic logic [7:0] romModel(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] tableModel(input int i);
    if (i % 2 == 1) return 8'h01;
    if (i == 4) return 8'h04;
    if (i == 10) return 8'h08;
    if (i == 14) return 8'h0C;
    return 8'h00;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R3 R5 R6: real host read, count edges to valid
  task automatic hostRead(input logic [15:0] a, input bit fast);
    int n = 0;
    int exp = fast ? 6 : 8;
    bit csOk = 1;
    @(negedge clk);
    hostAddr = a; hostFast = fast; hostReq = 1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      n++;
      if (!romCs) csOk = 0;
      if (hostValid) break;
    end
    check(n == exp, "R5 latency", n, exp);
    check(csOk, "R6 romCs high through access", csOk, 1);
    check(hostData == romModel(a) && romAddr == a, "R3 host data", hostData, romModel(a));
    hostReq = 0;
    @(negedge clk);
    check(!romCs && !hostValid, "R6 single valid", hostValid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!cpGrant && !romCs && !hostValid && !cpValid, "R8 reset", cpGrant, 0);
    rstN = 1;

    for (int i = 0; i < 16; i++) hostRead(16'h1230 + 16'(i * 17), i[0]);

    // R1 R2: fixed-table sweep
    @(negedge clk); cpRunning = 1; cpOwnsRom = 1;
    @(negedge clk);
    check(cpGrant, "R7 grant follows handover", cpGrant, 1);
    for (int hi = 0; hi < 4; hi++)
      for (int i = 0; i < 16; i++) begin
        hostAddr = 16'(hi * 16'h4410 + i); hostReq = 1;
        #1;
        check(hostValid && hostData == tableModel(i), "R1 table byte", hostData, tableModel(i));
        @(negedge clk);
        check(!romCs, "R2 no chip select", romCs, 0);
      end
    hostReq = 0;

    // R1 requires both bits: one bit alone gives real ROM
    cpRunning = 0; cpOwnsRom = 1;
    @(negedge clk);
    hostRead(16'h00FC, 1);
    cpRunning = 1; cpOwnsRom = 0;
    @(negedge clk);
    hostRead(16'hBEEF, 0);

    // R4: coprocessor held while host owns
    cpRunning = 0; cpOwnsRom = 0;
    cpAddr = 16'h7E31; cpFast = 1; cpReq = 1;
    begin
      bit quiet = 1;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (cpGrant || cpValid || romCs) quiet = 0;
      end
      check(quiet, "R4 coprocessor stalled", quiet, 1);
    end
    cpRunning = 1; cpOwnsRom = 1;
    begin
      int n = 0;
      @(negedge clk); n++;
      check(cpGrant, "R4 grant one edge after handover", cpGrant, 1);
      for (int k = 0; k < 20; k++) begin
        @(negedge clk); n++;
        if (cpValid) break;
      end
      check(n == 7, "R4 R5 cp served after handover", n, 7);
      check(cpData == romModel(16'h7E31), "R4 cp data", cpData, romModel(16'h7E31));
      cpReq = 0;
    end

    // R9 R7: ownership dropped mid access
    @(negedge clk);
    cpAddr = 16'h0A0B; cpFast = 0; cpReq = 1;
    begin
      int n = 0;
      bit grantHeld = 1;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk); n++;
        if (n == 3) cpRunning = 0;
        if (!cpGrant) grantHeld = 0;
        if (cpValid) break;
      end
      check(n == 8, "R9 access completes", n, 8);
      check(grantHeld, "R7 grant held in flight", grantHeld, 1);
      check(cpData == romModel(16'h0A0B), "R9 owner data", cpData, romModel(16'h0A0B));
      cpReq = 0;
      @(negedge clk);
      check(!cpGrant && !romCs, "R7 grant drops at boundary", cpGrant, 0);
    end
    hostRead(16'h5555, 1);
    done = 1;
  end

  initial begin
    for (int t = 0; t < 100000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) check(0, "watchdog", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule